// File: doc/BRIEF.md
# Control Register Read-Modify-Write Unit

This unit carries out the three control-register access forms of a processor (swap, bit-set and bit-clear) against a private bank of eight registers. A request presents the access form, whether the operand comes from a source register or from the 5-bit field that normally names that register, the destination and source register indices, the source register's value, a 12-bit register address and the active data width (32 or 64 bits). One clock later the unit returns the register's previous contents for the destination register, together with single-cycle pulses that mark whether a read side effect and a write side effect took place.

Every access is handled as one masked merge: the new value keeps the old bits where the mask is clear and takes the source bits where it is set. A swap uses the operand as source under a full-width mask. A set uses an all-ones source and the operand as mask. A clear uses a zero source and the operand as mask. The suppression rules remove the read or the write itself, not only its value. A swap whose destination index is zero performs no read. A set or clear whose source index field is zero performs no write. A source register that holds zero but has a nonzero index still causes a write. Privilege checking, trap generation and pipeline flushing belong to the surrounding core.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset all eight bank registers read as zero, and `respValid`, `respData`, `respReadFx`, `respWriteFx` and `respIllegal` are all zero.
- R2: A swap (`reqOp` = 2'b01) sets the register to `(old & ~mask) | (operand & mask)`, where the mask is the full active width, and returns the old value when the destination index is nonzero.
- R3: A set (`reqOp` = 2'b10) ORs the operand into the register, and a clear (`reqOp` = 2'b11) removes the operand bits from it. Both always read the register, return the old value and pulse `respReadFx`.
- R4: A swap with `reqRd` = 0 still writes and pulses `respWriteFx`, but it does not read: `respReadFx` stays low and `respData` is zero.
- R5: A set or clear with `reqRs1` = 0 does not write the register and does not pulse `respWriteFx`, whatever `reqRs1Val` holds. It still returns the old value.
- R6: A set or clear with a nonzero `reqRs1` whose value is zero leaves the contents unchanged but still pulses `respWriteFx`.
- R7: When `reqUseImm` = 1, the operand is `reqRs1` zero-extended, `reqRs1Val` is ignored, and the suppression test of R5 uses that 5-bit value being zero.
- R8: When `reqMode64` = 0, the operand and the swap mask cover bits 31:0 only. Bits 63:32 of the register are preserved, and `respData` bits 63:32 are zero.
- R9: A request whose address bits 11:3 differ from 9'h060 (so the implemented addresses are 0x300 to 0x307, with bits 2:0 selecting the register), or whose `reqOp` is 2'b00, pulses `respIllegal`. It changes no register, raises no side-effect pulse and returns zero data.
- R10: Each request produces its response on the next clock cycle. The returned data is the value before the update, and a request issued in the following cycle sees the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | Access form: 01 swap, 10 set, 11 clear, 00 reserved |
| reqUseImm | input | 1 | Use the 5-bit index field as the operand |
| reqRd | input | 5 | Destination register index |
| reqRs1 | input | 5 | Source register index or immediate |
| reqRs1Val | input | 64 | Source register value |
| reqAddr | input | 12 | Control register address |
| reqMode64 | input | 1 | 1 for 64-bit width, 0 for 32-bit width |
| respValid | output | 1 | Response present |
| respData | output | 64 | Old register value for the destination |
| respReadFx | output | 1 | A read took place |
| respWriteFx | output | 1 | A write took place |
| respIllegal | output | 1 | Address or access form not implemented |

## Verification
The bench uses the default parameters: a 64-bit datapath, eight registers and the page 9'h060. The 64-bit width lets the same instance run in both widths, so the bench can check that upper bits survive a 32-bit access. The 12-bit address leaves room for pages outside the bank, which exercises the illegal path. Requests are issued back to back, so a read immediately follows the write it depends on. Each suppression case is driven with a nonzero `reqRs1Val`, so that a missed suppression would show up as a changed register.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  localparam int REG_IDX_W = 5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_SWAP  = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csrOp_e;

  typedef enum logic [1:0] {
    SRC_OPERAND = 2'd0,
    SRC_ONES    = 2'd1,
    SRC_ZERO    = 2'd2
  } srcSel_e;

  typedef enum logic {
    MASK_WIDTH   = 1'b0,
    MASK_OPERAND = 1'b1
  } maskSel_e;

  typedef struct packed {
    logic     valid;
    logic     legal;
    logic     doRead;
    logic     doWrite;
    logic     mode64;
    srcSel_e  srcSel;
    maskSel_e maskSel;
  } csrStrobe_t;

endpackage

// File: rtl/csr_rmw_ctrl.sv
module csr_rmw_ctrl
  import csr_rmw_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int ADDR_W    = 12,
  parameter int NUM_REGS  = 8,
  parameter int BASE_PAGE = 'h060
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [1:0]                  reqOp,
  input  logic                        reqUseImm,
  input  logic [REG_IDX_W-1:0]        reqRd,
  input  logic [REG_IDX_W-1:0]        reqRs1,
  input  logic [XLEN-1:0]             reqRs1Val,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqMode64,
  output csrStrobe_t                  stb,
  output logic [XLEN-1:0]             operand,
  output logic [$clog2(NUM_REGS)-1:0] regIdx
);

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam int HALF   = XLEN / 2;

  csrOp_e          opKind;
  logic [XLEN-1:0] widthMask;
  logic [XLEN-1:0] rawOperand;
  logic            pageHit;
  logic            srcFieldZero;

  assign opKind       = csrOp_e'(reqOp);
  assign widthMask    = {{HALF{reqMode64}}, {HALF{1'b1}}};
  assign rawOperand   = reqUseImm ? {{(XLEN-REG_IDX_W){1'b0}}, reqRs1} : reqRs1Val;
  assign operand      = rawOperand & widthMask;
  assign pageHit      = (reqAddr[ADDR_W-1:IDX_W] == PAGE_W'(BASE_PAGE));
  assign regIdx       = reqAddr[IDX_W-1:0];
  assign srcFieldZero = (reqRs1 == '0);

  always_comb begin
    stb         = '0;
    stb.valid   = reqValid;
    stb.mode64  = reqMode64;
    stb.legal   = pageHit && (opKind != OP_NONE);
    stb.srcSel  = SRC_OPERAND;
    stb.maskSel = MASK_WIDTH;
    unique case (opKind)
      OP_SWAP: begin
        stb.doRead  = (reqRd != '0);
        stb.doWrite = 1'b1;
      end
      OP_SET: begin
        stb.doRead  = 1'b1;
        stb.doWrite = !srcFieldZero;
        stb.srcSel  = SRC_ONES;
        stb.maskSel = MASK_OPERAND;
      end
      OP_CLEAR: begin
        stb.doRead  = 1'b1;
        stb.doWrite = !srcFieldZero;
        stb.srcSel  = SRC_ZERO;
        stb.maskSel = MASK_OPERAND;
      end
      default: begin
        stb.doRead  = 1'b0;
        stb.doWrite = 1'b0;
      end
    endcase
  end

  p_imm_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqUseImm |-> operand < XLEN'(32));

  p_setclr_reads_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.valid && stb.maskSel == MASK_OPERAND && opKind != OP_NONE |-> stb.doRead);

endmodule

// File: rtl/csr_rmw_dp.sv
module csr_rmw_dp
  import csr_rmw_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  csrStrobe_t                  stb,
  input  logic [XLEN-1:0]             operand,
  input  logic [$clog2(NUM_REGS)-1:0] regIdx,
  output logic                        respValid,
  output logic [XLEN-1:0]             respData,
  output logic                        respReadFx,
  output logic                        respWriteFx,
  output logic                        respIllegal
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] bank [NUM_REGS];
  logic [XLEN-1:0] oldVal;
  logic [XLEN-1:0] srcVal;
  logic [XLEN-1:0] maskVal;
  logic [XLEN-1:0] newVal;
  logic [XLEN-1:0] widthMask;
  logic            accept;
  logic            readNow;
  logic            writeNow;

  assign accept    = stb.valid && stb.legal;
  assign readNow   = accept && stb.doRead;
  assign writeNow  = accept && stb.doWrite;
  assign widthMask = {{HALF{stb.mode64}}, {HALF{1'b1}}};
  assign oldVal    = bank[regIdx];

  always_comb begin
    unique case (stb.srcSel)
      SRC_ONES: srcVal = '1;
      SRC_ZERO: srcVal = '0;
      default:  srcVal = operand;
    endcase
    maskVal = (stb.maskSel == MASK_OPERAND) ? operand : widthMask;
    newVal  = (oldVal & ~maskVal) | (srcVal & maskVal);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bank[g] <= '0;
      end else if (writeNow && regIdx == g[$clog2(NUM_REGS)-1:0]) begin
        bank[g] <= newVal;
      end
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.valid && stb.legal && stb.doWrite) |=> $stable(bank[g]));

    p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
      stb.valid && !stb.mode64 |=> $stable(bank[g][XLEN-1:HALF]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respData    <= '0;
      respReadFx  <= 1'b0;
      respWriteFx <= 1'b0;
      respIllegal <= 1'b0;
    end else begin
      respValid   <= stb.valid;
      respData    <= readNow ? (oldVal & widthMask) : '0;
      respReadFx  <= readNow;
      respWriteFx <= writeNow;
      respIllegal <= stb.valid && !stb.legal;
    end
  end

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    respIllegal |-> !respReadFx && !respWriteFx && respData == '0);

  p_noread_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !respReadFx |-> respData == '0);

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int ADDR_W    = 12,
  parameter int NUM_REGS  = 8,
  parameter int BASE_PAGE = 'h060
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic                 reqUseImm,
  input  logic [REG_IDX_W-1:0] reqRd,
  input  logic [REG_IDX_W-1:0] reqRs1,
  input  logic [XLEN-1:0]      reqRs1Val,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqMode64,
  output logic                 respValid,
  output logic [XLEN-1:0]      respData,
  output logic                 respReadFx,
  output logic                 respWriteFx,
  output logic                 respIllegal
);

  localparam int IDX_W = $clog2(NUM_REGS);

  csrStrobe_t       stb;
  logic [XLEN-1:0]  operand;
  logic [IDX_W-1:0] regIdx;

  csr_rmw_ctrl #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE_PAGE(BASE_PAGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqUseImm(reqUseImm), .reqRd(reqRd), .reqRs1(reqRs1),
    .reqRs1Val(reqRs1Val), .reqAddr(reqAddr), .reqMode64(reqMode64),
    .stb(stb), .operand(operand), .regIdx(regIdx)
  );

  csr_rmw_dp #(
    .XLEN(XLEN), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .operand(operand), .regIdx(regIdx),
    .respValid(respValid), .respData(respData), .respReadFx(respReadFx),
    .respWriteFx(respWriteFx), .respIllegal(respIllegal)
  );

  p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid && !respReadFx && !respWriteFx && !respIllegal);

endmodule

// File: tb/csr_rmw_unit_tb.sv
`timescale 1ns/1ps
module csr_rmw_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'b00;
  logic        reqUseImm = 1'b0;
  logic [4:0]  reqRd = '0;
  logic [4:0]  reqRs1 = '0;
  logic [63:0] reqRs1Val = '0;
  logic [11:0] reqAddr = '0;
  logic        reqMode64 = 1'b1;
  logic        respValid;
  logic [63:0] respData;
  logic        respReadFx;
  logic        respWriteFx;
  logic        respIllegal;

  int vecCount = 0;
  int failCount = 0;

  typedef struct {
    logic [63:0] data;
    logic        rf;
    logic        wf;
    logic        il;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [63:0] model [8];

  always #4 clk = ~clk;

  csr_rmw_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqUseImm(reqUseImm), .reqRd(reqRd), .reqRs1(reqRs1),
    .reqRs1Val(reqRs1Val), .reqAddr(reqAddr), .reqMode64(reqMode64),
    .respValid(respValid), .respData(respData), .respReadFx(respReadFx),
    .respWriteFx(respWriteFx), .respIllegal(respIllegal)
  );

  task automatic issue(input logic [1:0] op, input logic imm, input logic [4:0] rd,
                       input logic [4:0] rs1, input logic [63:0] val,
                       input logic [11:0] addr, input logic m64, input string tag);
    exp_t        e;
    logic [63:0] xm;
    logic [63:0] opnd;
    logic [63:0] old;
    logic [63:0] nv;
    logic        legal;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqUseImm = imm; reqRd = rd; reqRs1 = rs1;
    reqRs1Val = val; reqAddr = addr; reqMode64 = m64;
    xm    = m64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    opnd  = (imm ? {59'd0, rs1} : val) & xm;
    legal = (op != 2'b00) && (addr[11:3] == 9'h060);
    old   = model[addr[2:0]];
    nv    = old;
    e.tag = tag; e.rf = 1'b0; e.wf = 1'b0; e.il = !legal; e.data = '0;
    if (legal) begin
      case (op)
        2'b01: begin e.rf = (rd != 0); e.wf = 1'b1; nv = (old & ~xm) | opnd; end
        2'b10: begin e.rf = 1'b1; e.wf = (rs1 != 0); nv = old | opnd; end
        default: begin e.rf = 1'b1; e.wf = (rs1 != 0); nv = old & ~opnd; end
      endcase
      if (e.rf) e.data = old & xm;
      if (e.wf) model[addr[2:0]] = nv;
    end
    @(posedge clk);
    #1;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rstN && respValid) begin
      exp_t e;
      vecCount++;
      if (expQ.size() == 0) begin
        failCount++;
        $display("FAIL R10 unexpected response: actual data=%h expected no response", respData);
      end else begin
        e = expQ.pop_front();
        if (respData !== e.data || respReadFx !== e.rf || respWriteFx !== e.wf ||
            respIllegal !== e.il) begin
          failCount++;
          $display("FAIL %s: actual data=%h rfx=%b wfx=%b ill=%b expected data=%h rfx=%b wfx=%b ill=%b",
                   e.tag, respData, respReadFx, respWriteFx, respIllegal,
                   e.data, e.rf, e.wf, e.il);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: outputs quiet after reset
    vecCount++;
    if (respValid !== 1'b0 || respData !== '0 || respReadFx !== 1'b0 ||
        respWriteFx !== 1'b0 || respIllegal !== 1'b0) begin
      failCount++;
      $display("FAIL R1 reset outputs: actual v=%b d=%h expected v=0 d=0", respValid, respData);
    end
    // R1: every register reads zero (set, source index 0 is a pure read)
    for (int i = 0; i < 8; i++)
      issue(2'b10, 1'b0, 5'd1, 5'd0, 64'hFFFF, 12'h300 + 12'(i), 1'b1, "R1 reset value");

    // R2 / R10: swap then back-to-back read of the new value
    issue(2'b01, 1'b0, 5'd5, 5'd3, 64'hDEAD_BEEF_0123_4567, 12'h301, 1'b1, "R2 swap old");
    issue(2'b01, 1'b0, 5'd5, 5'd3, 64'h0F0F_0000_FFFF_1111, 12'h301, 1'b1, "R10 sees update");
    issue(2'b10, 1'b0, 5'd2, 5'd0, 64'h0, 12'h301, 1'b1, "R2 readback");

    // R3: set and clear through a register operand
    issue(2'b10, 1'b0, 5'd4, 5'd9, 64'hF000_0000_0000_00F0, 12'h302, 1'b1, "R3 set");
    issue(2'b11, 1'b0, 5'd4, 5'd9, 64'h8000_0000_0000_0030, 12'h302, 1'b1, "R3 clear");
    issue(2'b10, 1'b0, 5'd4, 5'd0, 64'h0, 12'h302, 1'b1, "R3 readback");

    // R4: swap to x0 writes without reading
    issue(2'b01, 1'b0, 5'd0, 5'd6, 64'h1234_5678_9ABC_DEF0, 12'h303, 1'b1, "R4 no read");
    issue(2'b10, 1'b0, 5'd1, 5'd0, 64'h0, 12'h303, 1'b1, "R4 write landed");

    // R5: set/clear with source index 0 and nonzero value must not write
    issue(2'b10, 1'b0, 5'd1, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h303, 1'b1, "R5 set suppressed");
    issue(2'b11, 1'b0, 5'd1, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h303, 1'b1, "R5 clear suppressed");
    issue(2'b10, 1'b0, 5'd1, 5'd0, 64'h0, 12'h303, 1'b1, "R5 unchanged");

    // R6: nonzero index holding zero still writes
    issue(2'b10, 1'b0, 5'd1, 5'd7, 64'h0, 12'h303, 1'b1, "R6 set zero value");
    issue(2'b11, 1'b0, 5'd1, 5'd7, 64'h0, 12'h303, 1'b1, "R6 clear zero value");

    // R7: immediate forms ignore the register value
    issue(2'b10, 1'b1, 5'd1, 5'h15, 64'hFFFF_FFFF_FFFF_FF00, 12'h304, 1'b1, "R7 set imm");
    issue(2'b11, 1'b1, 5'd1, 5'h05, 64'hFFFF_FFFF_FFFF_FFFF, 12'h304, 1'b1, "R7 clear imm");
    issue(2'b10, 1'b1, 5'd1, 5'h00, 64'hFFFF_FFFF_FFFF_FFFF, 12'h304, 1'b1, "R7 imm zero suppress");
    issue(2'b01, 1'b1, 5'd1, 5'h1F, 64'hAAAA_AAAA_AAAA_AAAA, 12'h304, 1'b1, "R7 swap imm");
    issue(2'b10, 1'b1, 5'd1, 5'h00, 64'h0, 12'h304, 1'b1, "R7 readback");

    // R8: 32-bit width keeps the upper half
    issue(2'b01, 1'b0, 5'd1, 5'd2, 64'hCAFE_F00D_5555_5555, 12'h305, 1'b1, "R8 seed");
    issue(2'b01, 1'b0, 5'd1, 5'd2, 64'hFFFF_FFFF_1234_0000, 12'h305, 1'b0, "R8 swap narrow");
    issue(2'b10, 1'b0, 5'd1, 5'd2, 64'hFFFF_FFFF_0000_00FF, 12'h305, 1'b0, "R8 set narrow");
    issue(2'b11, 1'b0, 5'd1, 5'd2, 64'hFFFF_FFFF_0000_0F00, 12'h305, 1'b0, "R8 clear narrow");
    issue(2'b10, 1'b0, 5'd1, 5'd0, 64'h0, 12'h305, 1'b1, "R8 upper kept");

    // R9: outside the page and reserved form
    issue(2'b01, 1'b0, 5'd1, 5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 12'h345, 1'b1, "R9 bad page");
    issue(2'b00, 1'b0, 5'd1, 5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 12'h305, 1'b1, "R9 reserved op");
    issue(2'b10, 1'b0, 5'd1, 5'd0, 64'h0, 12'h305, 1'b1, "R9 unchanged");
    issue(2'b10, 1'b0, 5'd1, 5'd0, 64'h0, 12'h307, 1'b1, "R9 last entry");
    idle();

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      failCount++;
      $display("FAIL R10 missing responses: actual %0d pending expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule